// File: doc/BRIEF.md
# Discrete Label Update Combiner

This block sits after a set of parallel evidence rows in a discrete relaxation labeling engine. Each clock it may accept one object: an M-bit evidence vector, one bit per label, and that object's current M-bit label vector. It returns the refined label vector, which is the bitwise AND of the two. This means a label survives only when the object already holds it and the rows found support for it. Objects stream through at one per clock, and gaps in the input stream are carried through unchanged.

The pipeline has five register stages. Only the third stage does any work. The other four only register the data, so the stream keeps the same timing as a richer arithmetic combiner. The old label vector travels with the new one, so both appear at the output together.

The block counts the accepted objects in groups of N, where each group is one iteration over the object set. At the end of each group it reports whether any label bit of any object changed. A group with no change is a consistent labeling, and the outer iteration can then stop without reading back any data.

Top module: `lbl_combiner`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_valid`, `out_sweep_end` and `out_consistent` are 0, and `out_new` and `out_old` are 0.
- R2: For each accepted object, `out_new` equals `in_old & in_evid` of that object. As a result, `out_new` never has a bit set that `out_old` lacks.
- R3: An object accepted at a rising edge (`in_valid` = 1) appears with `out_valid` = 1 exactly five rising edges later. Back-to-back objects come out back-to-back, and idle cycles come out as idle cycles.
- R4: `out_old` carries the `in_old` vector of the same object that `out_new` belongs to.
- R5: Accepted objects are numbered 0..N-1 in arrival order from reset, wrapping after N-1. Idle cycles do not advance the count. `out_sweep_end` is 1 together with the output of every object numbered N-1, and 0 otherwise.
- R6: `out_consistent` is 1 together with `out_sweep_end` exactly when, for all N objects of that group, `out_new` equalled `out_old`. At all other times it is 0.
- R7: A change in even one bit of one object blocks `out_consistent` for that group only. The next group is judged on its own objects.
- R8: Cycles with `in_valid` = 0 have no effect. They produce no output object, and they neither alter nor split the change record of the group in progress.
- R9: A group whose label and evidence vectors are all ones, which is the starting labeling, is reported consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An object is presented this cycle |
| in_evid | input | M | Evidence vector, one bit per label |
| in_old | input | M | Current label vector of the object |
| out_valid | output | 1 | An updated object is present |
| out_new | output | M | Updated label vector |
| out_old | output | M | Label vector before the update |
| out_sweep_end | output | 1 | Last object of a group of N |
| out_consistent | output | 1 | No label bit changed in the group just finished |

## Verification
Every per-object result (`out_valid`, `out_new`, `out_old`) is due five rising edges after the edge that accepted the object. The group verdicts `out_sweep_end` and `out_consistent` are due in that same cycle, alongside the last object of the group. The bench drives on falling edges and records each expectation in a small ring indexed by cycle. It then compares that slot on the falling edge five cycles later, so every output is sampled in the middle of the cycle in which it is valid. The expected group verdicts come from a running object count and change flag kept in the bench. Idle cycles leave both of these untouched.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

    // Operation performed by a pipeline stage on the label vector
    typedef enum logic [0:0] {
        OP_PASS = 1'b0,
        OP_AND  = 1'b1
    } stage_op_e;

    // Width of a counter holding 0..n-1 (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lbl_obj_tracker.sv
module lbl_obj_tracker
    import lbl_pkg::*;
#(
    parameter int unsigned N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic first_o,
    output logic last_o
);

    localparam int unsigned IW = cnt_width(N);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_o = (st_q.idx == '0);
    assign last_o  = (st_q.idx == LAST_IDX);

endmodule

// File: rtl/lbl_stage.sv
module lbl_stage
    import lbl_pkg::*;
#(
    parameter int unsigned M  = 3,
    parameter stage_op_e   OP = OP_PASS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         i_valid,
    input  logic         i_first,
    input  logic         i_last,
    input  logic [M-1:0] i_vec,
    input  logic [M-1:0] i_old,
    output logic         o_valid,
    output logic         o_first,
    output logic         o_last,
    output logic [M-1:0] o_vec,
    output logic [M-1:0] o_old
);

    typedef struct packed {
        logic         valid;
        logic         first;
        logic         last;
        logic [M-1:0] vec;
        logic [M-1:0] old;
    } stg_t;

    stg_t st_d, st_q;
    logic [M-1:0] op_vec;

    generate
        if (OP == OP_AND) begin : g_and
            assign op_vec = i_vec & i_old;
        end else begin : g_pass
            assign op_vec = i_vec;
        end
    endgenerate

    always_comb begin
        st_d.valid = i_valid;
        st_d.first = i_valid & i_first;
        st_d.last  = i_valid & i_last;
        st_d.vec   = op_vec;
        st_d.old   = i_old;
        if (!i_valid) begin
            st_d.vec = '0;
            st_d.old = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.valid;
    assign o_first = st_q.first;
    assign o_last  = st_q.last;
    assign o_vec   = st_q.vec;
    assign o_old   = st_q.old;

endmodule

// File: rtl/lbl_change_monitor.sv
module lbl_change_monitor #(
    parameter int unsigned M = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         first_i,
    input  logic         last_i,
    input  logic [M-1:0] new_i,
    input  logic [M-1:0] old_i,
    output logic         sweep_end_o,
    output logic         consistent_o
);

    typedef struct packed {
        logic changed;
        logic sweep_end;
        logic consistent;
    } mon_t;

    mon_t st_d, st_q;
    logic any_diff;
    logic base;
    logic merged;

    assign any_diff = |(new_i ^ old_i);
    assign base     = first_i ? 1'b0 : st_q.changed;
    assign merged   = base | any_diff;

    always_comb begin
        st_d            = st_q;
        st_d.sweep_end  = 1'b0;
        st_d.consistent = 1'b0;
        if (valid_i) begin
            st_d.changed = merged;
            if (last_i) begin
                st_d.sweep_end  = 1'b1;
                st_d.consistent = ~merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sweep_end_o  = st_q.sweep_end;
    assign consistent_o = st_q.consistent;

endmodule

// File: rtl/lbl_combiner.sv
module lbl_combiner
    import lbl_pkg::*;
#(
    parameter int unsigned M = 3,
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [M-1:0] in_evid,
    input  logic [M-1:0] in_old,
    output logic         out_valid,
    output logic [M-1:0] out_new,
    output logic [M-1:0] out_old,
    output logic         out_sweep_end,
    output logic         out_consistent
);

    // Register stage, pass, AND, pass, pass
    localparam int unsigned NSTG   = 5;
    localparam int unsigned AND_AT = 2;
    localparam int unsigned TAP    = NSTG - 1;

    logic         v_s   [0:NSTG];
    logic         f_s   [0:NSTG];
    logic         l_s   [0:NSTG];
    logic [M-1:0] vec_s [0:NSTG];
    logic [M-1:0] old_s [0:NSTG];

    assign v_s[0]   = in_valid;
    assign vec_s[0] = in_evid;
    assign old_s[0] = in_old;

    lbl_obj_tracker #(.N(N)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .first_o (f_s[0]),
        .last_o  (l_s[0])
    );

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stg
            localparam stage_op_e SOP = (s == AND_AT) ? OP_AND : OP_PASS;
            lbl_stage #(.M(M), .OP(SOP)) u_stg (
                .clk     (clk),
                .rst_n   (rst_n),
                .i_valid (v_s[s]),
                .i_first (f_s[s]),
                .i_last  (l_s[s]),
                .i_vec   (vec_s[s]),
                .i_old   (old_s[s]),
                .o_valid (v_s[s+1]),
                .o_first (f_s[s+1]),
                .o_last  (l_s[s+1]),
                .o_vec   (vec_s[s+1]),
                .o_old   (old_s[s+1])
            );
        end
    endgenerate

    // Monitor registers in parallel with the last stage to stay aligned
    lbl_change_monitor #(.M(M)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (v_s[TAP]),
        .first_i      (f_s[TAP]),
        .last_i       (l_s[TAP]),
        .new_i        (vec_s[TAP]),
        .old_i        (old_s[TAP]),
        .sweep_end_o  (out_sweep_end),
        .consistent_o (out_consistent)
    );

    assign out_valid = v_s[NSTG];
    assign out_new   = vec_s[NSTG];
    assign out_old   = old_s[NSTG];

endmodule

// File: rtl/lbl_combiner_chk.sv
module lbl_combiner_chk #(
    parameter int unsigned M = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [M-1:0] in_evid,
    input logic [M-1:0] in_old,
    input logic         out_valid,
    input logic [M-1:0] out_new,
    input logic [M-1:0] out_old,
    input logic         out_sweep_end,
    input logic         out_consistent
);

    // Edges seen since reset release, saturating
    logic [2:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && out_valid) |-> (out_new == $past(in_old & in_evid, 5)));

    p_old_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5 && out_valid) |-> (out_old == $past(in_old, 5)));

    p_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_new & ~out_old) == '0));

    p_end_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sweep_end |-> out_valid);

    p_cons_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_consistent |-> (out_sweep_end && out_new == out_old));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sweep_end && !out_consistent));

endmodule

bind lbl_combiner lbl_combiner_chk #(.M(M)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_evid        (in_evid),
    .in_old         (in_old),
    .out_valid      (out_valid),
    .out_new        (out_new),
    .out_old        (out_old),
    .out_sweep_end  (out_sweep_end),
    .out_consistent (out_consistent)
);

// File: tb/sim_lbl_combiner.sv
`timescale 1ns/1ps
module sim_lbl_combiner;

    localparam int M   = 3;
    localparam int N   = 5;
    localparam int LAT = 5;
    localparam int RING = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [M-1:0] in_evid = '0;
    logic [M-1:0] in_old = '0;
    logic         out_valid;
    logic [M-1:0] out_new;
    logic [M-1:0] out_old;
    logic         out_sweep_end;
    logic         out_consistent;

    always #5 clk = ~clk;

    lbl_combiner #(.M(M), .N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_evid(in_evid),
        .in_old(in_old), .out_valid(out_valid), .out_new(out_new),
        .out_old(out_old), .out_sweep_end(out_sweep_end),
        .out_consistent(out_consistent)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // expectation ring
    logic         e_v   [RING];
    logic [M-1:0] e_new [RING];
    logic [M-1:0] e_old [RING];
    logic         e_end [RING];
    logic         e_con [RING];
    string        e_tag [RING];

    // bench model of grouping
    int  m_idx = 0;
    bit  m_flag = 0;
    int  cyc = 0;
    int  cons_expected = 0;
    string cur_tag = "R6";

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input logic v, input logic [M-1:0] o, input logic [M-1:0] e);
        int rd;
        int wr;
        @(negedge clk);
        rd = (cyc + RING - LAT) % RING;
        wr = cyc % RING;
        chk("R3 out_valid", int'(out_valid), int'(e_v[rd]));
        if (e_v[rd]) begin
            chk("R2 out_new", int'(out_new), int'(e_new[rd]));
            chk("R4 out_old", int'(out_old), int'(e_old[rd]));
        end
        chk("R5 sweep_end", int'(out_sweep_end), int'(e_end[rd]));
        chk({e_tag[rd], " consistent"}, int'(out_consistent), int'(e_con[rd]));
        // model the new entry
        e_v[wr]   = v;
        e_new[wr] = v ? (o & e) : '0;
        e_old[wr] = v ? o : '0;
        e_end[wr] = 1'b0;
        e_con[wr] = 1'b0;
        e_tag[wr] = cur_tag;
        if (v) begin
            m_flag = ((m_idx == 0) ? 1'b0 : m_flag) | ((o ^ (o & e)) != '0);
            if (m_idx == N - 1) begin
                e_end[wr] = 1'b1;
                e_con[wr] = !m_flag;
                if (!m_flag) cons_expected++;
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end
        in_valid = v;
        in_old   = o;
        in_evid  = e;
        cyc++;
    endtask

    task automatic align();
        while (m_idx != 0) step(1'b1, '1, '1);
    endtask

    initial begin
        for (int i = 0; i < RING; i++) begin
            e_v[i] = 0; e_new[i] = '0; e_old[i] = '0;
            e_end[i] = 0; e_con[i] = 0; e_tag[i] = "R1";
        end
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 out_valid", int'(out_valid), 0);
            chk("R1 sweep_end", int'(out_sweep_end), 0);
            chk("R1 consistent", int'(out_consistent), 0);
            chk("R1 out_new", int'(out_new), 0);
        end
        rst_n = 1'b1;

        // R2 R4: every label/evidence pair, back to back
        cur_tag = "R6";
        for (int o = 0; o < (1 << M); o++)
            for (int e = 0; e < (1 << M); e++)
                step(1'b1, M'(o), M'(e));

        // R8: pseudo-random idle gaps in the stream
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 80; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], lf[M:1], lf[M+4:5]);
            end
        end

        align();
        // R9: starting labeling, all ones
        cur_tag = "R9";
        for (int k = 0; k < N; k++) step(1'b1, '1, '1);
        // R6: arbitrary labels with full support
        cur_tag = "R6";
        for (int k = 0; k < N; k++) step(1'b1, M'(k + 2), '1);
        // R7: one bit lost in one object blocks this group only
        cur_tag = "R7";
        for (int k = 0; k < N; k++) step(1'b1, '1, (k == 3) ? M'((1 << M) - 3) : '1);
        for (int k = 0; k < N; k++) step(1'b1, M'(k), M'(k));
        // R8: idle cycles inside a group do not split it
        cur_tag = "R8";
        for (int k = 0; k < N; k++) begin
            step(1'b1, M'(k + 1), '1);
            step(1'b0, '1, '0);
        end
        // drain
        for (int k = 0; k < LAT + 3; k++) step(1'b0, '0, '0);

        chk("R6 consistent groups seen", (cons_expected >= 4) ? 1 : 0, 1);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL R3 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule